// File: doc/BRIEF.md
# Power Mode Override Selector

This block decides the power state of each channel of a two-channel converter. Each channel is in one of three states: normal, nap or sleep. An external mode pin arrives as an already decoded two-bit request and acts on every channel at once. Software can override the pin for each channel on its own through a 3-bit control field. The fields are written through an indexed port, where a write-enable mask picks the channel or channels that take the value.

A field value of zero hands the channel back to the pin. The three other defined codes force a fixed state. Any undefined code is read as normal operation and raises a sticky flag.

A hard (power-on) reset clears every field to zero and returns all outputs to their idle values. A soft reset leaves the fields and the resolved states alone and only clears the sticky flag. The resolved state of each channel is held in a register, so it moves exactly one clock after the write or pin change that caused it.

Top module: `pwr_mode_sel`

## Requirements
- R1: While `hardRstN` is low, every channel field reads 000, every channel state reads normal (00) and `badWrite` reads 0, whatever the pin request.
- R2: Field codes force the channel state one clock after the write: 001 gives normal (00), 010 gives nap (01) and 100 gives sleep (10).
- R3: A channel whose field is 000 follows the pin request, and the pin acts on all such channels together. Pin code 00 gives normal, 01 gives nap, 10 gives sleep and 11 gives normal.
- R4: A change on `pinReq` shows on the state of a deferring channel at the first rising clock edge after the change, and not before.
- R5: With `wrEn` high, bit i of `wrMask` loads `wrData` into the field of channel i (channel 0 is bit 0). With both bits set, both fields load in the same cycle. With a zero mask, no field changes.
- R6: A write never alters the field or the state of a channel whose mask bit is clear.
- R7: A field code outside {000, 001, 010, 100} is stored and read back unchanged, but it resolves to normal. A write of such a code with a nonzero mask sets `badWrite`.
- R8: `badWrite` stays set until a cycle with `softRst` high. Soft reset clears it and leaves every field and every channel state unchanged.
- R9: A channel state output never shows the code 11.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| hardRstN | input | 1 | Asynchronous power-on reset, active low |
| softRst | input | 1 | Synchronous soft reset, clears only the sticky flag |
| pinReq | input | 2 | Decoded mode pin request (00 normal, 01 nap, 10 sleep, 11 normal) |
| wrEn | input | 1 | Field write strobe |
| wrMask | input | 2 | Channel write-enable mask, bit i selects channel i |
| wrData | input | 3 | Field value to write |
| chState | output | 4 | Resolved state, channel i in bits [2i+1:2i] |
| chField | output | 6 | Stored control field, channel i in bits [3i+2:3i] |
| badWrite | output | 1 | Sticky flag for a write of an undefined code |

## Verification
Some rules are checked on every cycle. Masked writes must land in the right field, and unmasked fields must hold. Soft reset must not disturb the fields, the flag must stay sticky, and no state may show the illegal code 11. Fixed field codes must give their state on the next cycle, and a deferring channel must follow a sleep request from the pin. Other behaviour only the bench scenarios can show. These are the complete pin decode table including code 11, the exact edge at which a pin change appears, the two-channel simultaneous write, how undefined codes read back and resolve, and the clearing of the flag by soft reset.

// File: rtl/pwr_mode_pkg.sv
`timescale 1ns/1ps
package pwr_mode_pkg;
  localparam int NUM_CH  = 2;
  localparam int FIELD_W = 3;
  localparam int STATE_W = 2;
  localparam int PIN_W   = 2;

  typedef enum logic [STATE_W-1:0] {
    PS_NORMAL = 2'd0,
    PS_NAP    = 2'd1,
    PS_SLEEP  = 2'd2
  } pstate_e;

  localparam logic [FIELD_W-1:0] FLD_PIN    = 3'b000;
  localparam logic [FIELD_W-1:0] FLD_NORMAL = 3'b001;
  localparam logic [FIELD_W-1:0] FLD_NAP    = 3'b010;
  localparam logic [FIELD_W-1:0] FLD_SLEEP  = 3'b100;

  // strobes from control to datapath
  typedef struct packed {
    logic [NUM_CH-1:0] load;
    logic              setBad;
    logic              clrBad;
  } ctrl_s;

  function automatic pstate_e pinToState(input logic [PIN_W-1:0] p);
    case (p)
      2'b01:   return PS_NAP;
      2'b10:   return PS_SLEEP;
      default: return PS_NORMAL;
    endcase
  endfunction

  function automatic pstate_e resolveState(input logic [FIELD_W-1:0] f,
                                           input logic [PIN_W-1:0] p);
    case (f)
      FLD_PIN:   return pinToState(p);
      FLD_NAP:   return PS_NAP;
      FLD_SLEEP: return PS_SLEEP;
      default:   return PS_NORMAL;
    endcase
  endfunction

  function automatic logic isLegalField(input logic [FIELD_W-1:0] f);
    return (f == FLD_PIN) || (f == FLD_NORMAL) || (f == FLD_NAP) || (f == FLD_SLEEP);
  endfunction
endpackage

// File: rtl/pwr_mode_ctrl.sv
`timescale 1ns/1ps
module pwr_mode_ctrl
  import pwr_mode_pkg::*;
(
  input  logic                clk,
  input  logic                hardRstN,
  input  logic                softRst,
  input  logic                wrEn,
  input  logic [NUM_CH-1:0]   wrMask,
  input  logic [FIELD_W-1:0]  wrData,
  output ctrl_s               strobes,
  output logic                badWrite
);
  logic badQ;

  always_comb begin
    strobes.load   = wrEn ? wrMask : '0;
    strobes.setBad = wrEn && (|wrMask) && !isLegalField(wrData);
    strobes.clrBad = softRst;
  end

  // sticky flag: a new bad write in the clearing cycle wins
  always_ff @(posedge clk or negedge hardRstN) begin
    if (!hardRstN)           badQ <= 1'b0;
    else if (strobes.setBad) badQ <= 1'b1;
    else if (strobes.clrBad) badQ <= 1'b0;
  end

  assign badWrite = badQ;
endmodule

// File: rtl/pwr_mode_dp.sv
`timescale 1ns/1ps
module pwr_mode_dp
  import pwr_mode_pkg::*;
(
  input  logic                          clk,
  input  logic                          hardRstN,
  input  ctrl_s                         strobes,
  input  logic [FIELD_W-1:0]            wrData,
  input  logic [PIN_W-1:0]              pinReq,
  output logic [NUM_CH*STATE_W-1:0]     chState,
  output logic [NUM_CH*FIELD_W-1:0]     chField
);
  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
    logic [FIELD_W-1:0] fieldQ;
    logic [FIELD_W-1:0] fieldNext;
    pstate_e            stateQ;

    assign fieldNext = strobes.load[ch] ? wrData : fieldQ;

    // only the hard reset touches the field
    always_ff @(posedge clk or negedge hardRstN) begin
      if (!hardRstN) fieldQ <= FLD_PIN;
      else           fieldQ <= fieldNext;
    end

    // resolve from the incoming field so a write lands in one clock
    always_ff @(posedge clk or negedge hardRstN) begin
      if (!hardRstN) stateQ <= PS_NORMAL;
      else           stateQ <= resolveState(fieldNext, pinReq);
    end

    assign chField[ch*FIELD_W +: FIELD_W] = fieldQ;
    assign chState[ch*STATE_W +: STATE_W] = stateQ;
  end
endmodule

// File: rtl/pwr_mode_sel.sv
`timescale 1ns/1ps
module pwr_mode_sel
  import pwr_mode_pkg::*;
(
  input  logic        clk,
  input  logic        hardRstN,
  input  logic        softRst,
  input  logic [1:0]  pinReq,
  input  logic        wrEn,
  input  logic [1:0]  wrMask,
  input  logic [2:0]  wrData,
  output logic [3:0]  chState,
  output logic [5:0]  chField,
  output logic        badWrite
);
  ctrl_s strobes;

  pwr_mode_ctrl u_ctrl (
    .clk      (clk),
    .hardRstN (hardRstN),
    .softRst  (softRst),
    .wrEn     (wrEn),
    .wrMask   (wrMask),
    .wrData   (wrData),
    .strobes  (strobes),
    .badWrite (badWrite)
  );

  pwr_mode_dp u_dp (
    .clk      (clk),
    .hardRstN (hardRstN),
    .strobes  (strobes),
    .wrData   (wrData),
    .pinReq   (pinReq),
    .chState  (chState),
    .chField  (chField)
  );
endmodule

// File: rtl/pwr_mode_sel_chk.sv
`timescale 1ns/1ps
module pwr_mode_sel_chk
  import pwr_mode_pkg::*;
(
  input logic        clk,
  input logic        hardRstN,
  input logic        softRst,
  input logic [1:0]  pinReq,
  input logic        wrEn,
  input logic [1:0]  wrMask,
  input logic [2:0]  wrData,
  input logic [3:0]  chState,
  input logic [5:0]  chField,
  input logic        badWrite
);
  assert_flag_sticky_R8: assert property (@(posedge clk) disable iff (!hardRstN)
    badWrite && !softRst |=> badWrite);

  assert_soft_keeps_fields_R8: assert property (@(posedge clk) disable iff (!hardRstN)
    softRst && !wrEn |=> $stable(chField));

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chk
    assert_masked_load_R5: assert property (@(posedge clk) disable iff (!hardRstN)
      wrEn && wrMask[ch] |=> chField[ch*3 +: 3] == $past(wrData));

    assert_unmasked_hold_R6: assert property (@(posedge clk) disable iff (!hardRstN)
      !(wrEn && wrMask[ch]) |=> $stable(chField[ch*3 +: 3]));

    assert_no_code3_R9: assert property (@(posedge clk) disable iff (!hardRstN)
      chState[ch*2 +: 2] != 2'b11);

    assert_sleep_field_R2: assert property (@(posedge clk) disable iff (!hardRstN)
      chField[ch*3 +: 3] == 3'b100 && !(wrEn && wrMask[ch]) |=> chState[ch*2 +: 2] == 2'b10);

    assert_nap_field_R2: assert property (@(posedge clk) disable iff (!hardRstN)
      chField[ch*3 +: 3] == 3'b010 && !(wrEn && wrMask[ch]) |=> chState[ch*2 +: 2] == 2'b01);

    assert_pin_sleep_R3: assert property (@(posedge clk) disable iff (!hardRstN)
      chField[ch*3 +: 3] == 3'b000 && !(wrEn && wrMask[ch]) && pinReq == 2'b10
      |=> chState[ch*2 +: 2] == 2'b10);
  end
endmodule

bind pwr_mode_sel pwr_mode_sel_chk u_chk (
  .clk      (clk),
  .hardRstN (hardRstN),
  .softRst  (softRst),
  .pinReq   (pinReq),
  .wrEn     (wrEn),
  .wrMask   (wrMask),
  .wrData   (wrData),
  .chState  (chState),
  .chField  (chField),
  .badWrite (badWrite)
);

// File: tb/pwr_mode_sel_test.sv
`timescale 1ns/1ps
module pwr_mode_sel_test;
  logic       clk = 1'b0;
  logic       hardRstN = 1'b0;
  logic       softRst = 1'b0;
  logic [1:0] pinReq = 2'b00;
  logic       wrEn = 1'b0;
  logic [1:0] wrMask = 2'b00;
  logic [2:0] wrData = 3'b000;
  logic [3:0] chState;
  logic [5:0] chField;
  logic       badWrite;

  int total = 0;
  int bad = 0;

  always #2.5 clk = ~clk;

  pwr_mode_sel uut (
    .clk(clk), .hardRstN(hardRstN), .softRst(softRst), .pinReq(pinReq),
    .wrEn(wrEn), .wrMask(wrMask), .wrData(wrData),
    .chState(chState), .chField(chField), .badWrite(badWrite)
  );

  task automatic expectEq(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int stOf(input int ch);
    return int'(chState[ch*2 +: 2]);
  endfunction

  function automatic int fdOf(input int ch);
    return int'(chField[ch*3 +: 3]);
  endfunction

  task automatic writeField(input logic [1:0] mask, input logic [2:0] data);
    @(negedge clk);
    wrEn = 1'b1; wrMask = mask; wrData = data;
    @(negedge clk);
    wrEn = 1'b0; wrMask = 2'b00;
  endtask

  task automatic testReset();
    pinReq = 2'b10;
    repeat (3) @(negedge clk);
    expectEq("R1", "field0 in reset", fdOf(0), 0);
    expectEq("R1", "field1 in reset", fdOf(1), 0);
    expectEq("R1", "state0 in reset", stOf(0), 0);
    expectEq("R1", "state1 in reset", stOf(1), 0);
    expectEq("R1", "flag in reset", int'(badWrite), 0);
    hardRstN = 1'b1;
    @(negedge clk);
    expectEq("R3", "state0 follows sleep pin", stOf(0), 2);
    expectEq("R3", "state1 follows sleep pin", stOf(1), 2);
  endtask

  task automatic testPinDefer();
    for (int p = 0; p < 4; p++) begin
      int exp;
      int prev;
      prev = stOf(0);
      exp = (p == 1) ? 1 : (p == 2) ? 2 : 0;
      @(negedge clk);
      pinReq = 2'(p);
      #1;
      expectEq("R4", "state0 before edge", stOf(0), prev);
      @(negedge clk);
      expectEq("R3", "state0 pin decode", stOf(0), exp);
      expectEq("R3", "state1 pin decode", stOf(1), exp);
    end
  endtask

  task automatic testFieldCodes();
    pinReq = 2'b01;
    @(negedge clk);
    writeField(2'b01, 3'b001);
    expectEq("R2", "ch0 normal code", stOf(0), 0);
    expectEq("R2", "ch0 field readback", fdOf(0), 1);
    expectEq("R6", "ch1 still on nap pin", stOf(1), 1);
    writeField(2'b01, 3'b010);
    expectEq("R2", "ch0 nap code", stOf(0), 1);
    writeField(2'b01, 3'b100);
    expectEq("R2", "ch0 sleep code", stOf(0), 2);
    writeField(2'b10, 3'b001);
    expectEq("R6", "ch0 field kept", fdOf(0), 4);
    expectEq("R6", "ch0 state kept", stOf(0), 2);
    expectEq("R2", "ch1 normal code", stOf(1), 0);
  endtask

  task automatic testMask();
    writeField(2'b11, 3'b010);
    expectEq("R5", "both write field0", fdOf(0), 2);
    expectEq("R5", "both write field1", fdOf(1), 2);
    expectEq("R5", "both write state0", stOf(0), 1);
    expectEq("R5", "both write state1", stOf(1), 1);
    writeField(2'b00, 3'b100);
    expectEq("R5", "zero mask field0", fdOf(0), 2);
    expectEq("R5", "zero mask field1", fdOf(1), 2);
    expectEq("R5", "zero mask state1", stOf(1), 1);
    pinReq = 2'b10;
    writeField(2'b11, 3'b000);
    expectEq("R3", "back to pin ch0", stOf(0), 2);
    expectEq("R3", "back to pin ch1", stOf(1), 2);
  endtask

  task automatic testInvalid();
    pinReq = 2'b01;
    writeField(2'b00, 3'b111);
    expectEq("R7", "no flag on zero mask", int'(badWrite), 0);
    writeField(2'b10, 3'b111);
    expectEq("R7", "raw readback ch1", fdOf(1), 7);
    expectEq("R7", "undefined code is normal", stOf(1), 0);
    expectEq("R7", "flag set", int'(badWrite), 1);
    expectEq("R6", "ch0 still on pin", stOf(0), 1);
    writeField(2'b01, 3'b011);
    expectEq("R7", "code 011 is normal", stOf(0), 0);
    writeField(2'b01, 3'b100);
    repeat (3) @(negedge clk);
    expectEq("R8", "flag sticky", int'(badWrite), 1);
  endtask

  task automatic testSoftReset();
    @(negedge clk);
    softRst = 1'b1;
    @(negedge clk);
    softRst = 1'b0;
    expectEq("R8", "flag cleared", int'(badWrite), 0);
    expectEq("R8", "field0 kept", fdOf(0), 4);
    expectEq("R8", "field1 kept", fdOf(1), 7);
    expectEq("R8", "state0 kept", stOf(0), 2);
    expectEq("R8", "state1 kept", stOf(1), 0);
    @(negedge clk);
    expectEq("R9", "state0 legal", int'(stOf(0) != 3), 1);
    expectEq("R9", "state1 legal", int'(stOf(1) != 3), 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    testReset();
    testPinDefer();
    testFieldCodes();
    testMask();
    testInvalid();
    testSoftReset();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule